// File: doc/BRIEF.md
# Register Hazard Classifier

This block sits between instruction decode and issue. It holds a short window of older instructions that are still in flight, oldest in slot 0. Each cycle it compares a decoded candidate instruction against every occupied slot. The candidate has one destination register, two source registers and a valid flag for each. For each slot the block reports three flags: a read-after-write (true) dependency, a write-after-write (output) dependency and a write-after-read (anti) dependency. A single issue-ok signal combines all of them.

The issue logic appends an instruction to the window with a push strobe. Later it reports, one slot at a time, that the instruction has read its operands and that it has written its result. Entries whose results are written leave from the oldest end in program order. The remaining entries slide down so that the window always fills from slot 0 with no gaps. Execution units, operand forwarding and register renaming are handled elsewhere.

Top module: `reg_hazard_classifier`

## Requirements
- R1: `true_dep_o[i]` is 1 when slot i is occupied, its destination is valid and non-zero, its result is not yet written, and a valid candidate source equals that destination.
- R2: `out_dep_o[i]` is 1 when slot i is occupied, its destination is valid, non-zero and not yet written, and the valid candidate destination equals it.
- R3: `anti_dep_o[i]` is 1 when slot i is occupied, its operands are not yet read, and the valid, non-zero candidate destination equals one of that slot's valid sources.
- R4: Register index 0 never causes a hazard, and neither does a source or destination whose valid flag is 0, whether the field belongs to the candidate or to a window entry.
- R5: `issue_ok_o` is 1 exactly when no bit of the three hazard vectors is set. After reset it is 1 for any candidate.
- R6: When `win_full_o` is 0, a push stores the candidate in the lowest free slot, with read and written flags both clear. It appears in `slot_occ_o` after the clock edge. While `win_full_o` is 1, a push is dropped and leaves the window unchanged. After reset the window is empty.
- R7: Consider the entries that are marked written as of the start of a cycle. Starting from slot 0, the unbroken run of these entries is removed at that cycle's edge, and the survivors move down by the length of the run. A written entry behind an unwritten one stays until every older entry is written. `slot_occ_o` is always a run of ones starting at bit 0.
- R8: `mark_written_i[i]` also marks slot i as read. Marks on empty slots are ignored, including a slot that a push fills at the same edge. Marks change the hazard outputs from the cycle after the edge.
- R9: Consider the sequence R3=R3*R5, R4=R3+1, R3=R5+1, R7=R3/R4, with the first instruction's operands read. The second instruction shows a true dependency on the first. The third shows an output dependency on the first and an anti dependency on the second. Once the first instruction has been written and retired, the fourth shows true dependencies on the second and third.
- R10: No hazard flag is set for an empty slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Append the candidate to the window |
| new_dst_i | input | RW | Candidate destination register |
| new_dst_vld_i | input | 1 | Candidate destination valid |
| new_src1_i | input | RW | Candidate first source register |
| new_src1_vld_i | input | 1 | Candidate first source valid |
| new_src2_i | input | RW | Candidate second source register |
| new_src2_vld_i | input | 1 | Candidate second source valid |
| mark_read_i | input | NENT | Per slot: operands of that entry have been read |
| mark_written_i | input | NENT | Per slot: result of that entry has been written |
| true_dep_o | output | NENT | Per slot read-after-write hazard |
| out_dep_o | output | NENT | Per slot write-after-write hazard |
| anti_dep_o | output | NENT | Per slot write-after-read hazard |
| issue_ok_o | output | 1 | Candidate may issue now |
| slot_occ_o | output | NENT | Per slot occupancy |
| win_full_o | output | 1 | All slots occupied |

## Verification
Several properties are checked on every cycle. A hazard always blocks issue. A zero or invalid candidate field never raises a flag. Empty slots stay silent. Occupancy stays a gap-free run from slot 0, the full flag agrees with that run, and a push into a full window never grows it. Only the bench scenarios can show that each slot gets exactly the right flag for a given register pattern. They also cover partial in-order retirement, marks on empty slots, the write-implies-read rule, a push and a retirement at the same edge, and the four-instruction example. For these, the bench sweeps every candidate register and valid combination against several window contents.

// File: rtl/rhc_pkg.sv
package rhc_pkg;

    // Status flags kept for one window slot.
    typedef struct packed {
        logic vld;      // slot occupied
        logic dst_v;    // destination field meaningful
        logic s1_v;     // first source meaningful
        logic s2_v;     // second source meaningful
        logic rd_done;  // operands consumed
        logic wr_done;  // result produced
    } ent_flags_t;

endpackage

// File: rtl/rhc_cmp.sv
module rhc_cmp #(
    parameter int RW = 5
) (
    input  rhc_pkg::ent_flags_t ent_fl,
    input  logic [RW-1:0]       ent_dst,
    input  logic [RW-1:0]       ent_s1,
    input  logic [RW-1:0]       ent_s2,
    input  logic [RW-1:0]       cand_dst,
    input  logic                cand_dst_v,
    input  logic [RW-1:0]       cand_s1,
    input  logic                cand_s1_v,
    input  logic [RW-1:0]       cand_s2,
    input  logic                cand_s2_v,
    output logic                raw_o,
    output logic                waw_o,
    output logic                war_o
);
    logic pending_wr;
    logic pending_rd;
    logic cand_wr;

    always_comb begin
        // Older entry still owes a write to a real register.
        pending_wr = ent_fl.vld && ent_fl.dst_v && (ent_dst != '0) && !ent_fl.wr_done;
        // Older entry still owes its operand reads.
        pending_rd = ent_fl.vld && !ent_fl.rd_done;
        // Candidate writes a real register.
        cand_wr    = cand_dst_v && (cand_dst != '0);

        raw_o = pending_wr && ((cand_s1_v && (cand_s1 == ent_dst)) ||
                               (cand_s2_v && (cand_s2 == ent_dst)));
        waw_o = pending_wr && cand_wr && (cand_dst == ent_dst);
        war_o = pending_rd && cand_wr && ((ent_fl.s1_v && (ent_s1 == cand_dst)) ||
                                          (ent_fl.s2_v && (ent_s2 == cand_dst)));
    end
endmodule

// File: rtl/rhc_window.sv
module rhc_window #(
    parameter int NENT = 4,
    parameter int RW   = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push_i,
    input  logic [RW-1:0]                  in_dst,
    input  logic                           in_dst_v,
    input  logic [RW-1:0]                  in_s1,
    input  logic                           in_s1_v,
    input  logic [RW-1:0]                  in_s2,
    input  logic                           in_s2_v,
    input  logic [NENT-1:0]                mark_rd,
    input  logic [NENT-1:0]                mark_wr,
    output rhc_pkg::ent_flags_t [NENT-1:0] fl_o,
    output logic [NENT-1:0][RW-1:0]        dst_o,
    output logic [NENT-1:0][RW-1:0]        s1_o,
    output logic [NENT-1:0][RW-1:0]        s2_o,
    output logic [NENT-1:0]                occ_o,
    output logic                           full_o
);
    localparam int CW = $clog2(NENT + 1);

    typedef struct packed {
        rhc_pkg::ent_flags_t [NENT-1:0] fl;
        logic [NENT-1:0][RW-1:0]        dst;
        logic [NENT-1:0][RW-1:0]        s1;
        logic [NENT-1:0][RW-1:0]        s2;
        logic [CW-1:0]                  cnt;
    } win_t;

    win_t st_d, st_q;
    win_t upd;
    int   n_ret;
    logic stop;

    always_comb begin
        // Leading run of written entries, judged on registered state.
        n_ret = 0;
        stop  = 1'b0;
        for (int i = 0; i < NENT; i++) begin
            if (!stop && st_q.fl[i].vld && st_q.fl[i].wr_done) n_ret = n_ret + 1;
            else stop = 1'b1;
        end

        // Apply completion marks to occupied slots only.
        upd = st_q;
        for (int i = 0; i < NENT; i++) begin
            if (st_q.fl[i].vld) begin
                if (mark_rd[i] || mark_wr[i]) upd.fl[i].rd_done = 1'b1;
                if (mark_wr[i])               upd.fl[i].wr_done = 1'b1;
            end
        end

        // Compact toward slot 0 by the retired count.
        st_d = '0;
        for (int i = 0; i < NENT; i++) begin
            for (int j = 0; j < NENT; j++) begin
                if (j == i + n_ret) begin
                    st_d.fl[i]  = upd.fl[j];
                    st_d.dst[i] = upd.dst[j];
                    st_d.s1[i]  = upd.s1[j];
                    st_d.s2[i]  = upd.s2[j];
                end
            end
        end
        st_d.cnt = st_q.cnt - CW'(n_ret);

        // Append behind the survivors unless the window was full.
        if (push_i && (st_q.cnt != CW'(NENT))) begin
            for (int k = 0; k < NENT; k++) begin
                if (k == int'(st_q.cnt) - n_ret) begin
                    st_d.fl[k]  = '{vld: 1'b1, dst_v: in_dst_v, s1_v: in_s1_v,
                                    s2_v: in_s2_v, rd_done: 1'b0, wr_done: 1'b0};
                    st_d.dst[k] = in_dst;
                    st_d.s1[k]  = in_s1;
                    st_d.s2[k]  = in_s2;
                end
            end
            st_d.cnt = st_d.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        fl_o   = st_q.fl;
        dst_o  = st_q.dst;
        s1_o   = st_q.s1;
        s2_o   = st_q.s2;
        full_o = (st_q.cnt == CW'(NENT));
        for (int i = 0; i < NENT; i++) occ_o[i] = st_q.fl[i].vld;
    end
endmodule

// File: rtl/reg_hazard_classifier.sv
module reg_hazard_classifier #(
    parameter int NENT = 4,
    parameter int RW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_i,
    input  logic [RW-1:0]   new_dst_i,
    input  logic            new_dst_vld_i,
    input  logic [RW-1:0]   new_src1_i,
    input  logic            new_src1_vld_i,
    input  logic [RW-1:0]   new_src2_i,
    input  logic            new_src2_vld_i,
    input  logic [NENT-1:0] mark_read_i,
    input  logic [NENT-1:0] mark_written_i,
    output logic [NENT-1:0] true_dep_o,
    output logic [NENT-1:0] out_dep_o,
    output logic [NENT-1:0] anti_dep_o,
    output logic            issue_ok_o,
    output logic [NENT-1:0] slot_occ_o,
    output logic            win_full_o
);
    rhc_pkg::ent_flags_t [NENT-1:0] w_fl;
    logic [NENT-1:0][RW-1:0]        w_dst;
    logic [NENT-1:0][RW-1:0]        w_s1;
    logic [NENT-1:0][RW-1:0]        w_s2;

    rhc_window #(.NENT(NENT), .RW(RW)) win_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (push_i),
        .in_dst   (new_dst_i),
        .in_dst_v (new_dst_vld_i),
        .in_s1    (new_src1_i),
        .in_s1_v  (new_src1_vld_i),
        .in_s2    (new_src2_i),
        .in_s2_v  (new_src2_vld_i),
        .mark_rd  (mark_read_i),
        .mark_wr  (mark_written_i),
        .fl_o     (w_fl),
        .dst_o    (w_dst),
        .s1_o     (w_s1),
        .s2_o     (w_s2),
        .occ_o    (slot_occ_o),
        .full_o   (win_full_o)
    );

    for (genvar g = 0; g < NENT; g++) begin : g_cmp
        rhc_cmp #(.RW(RW)) cmp_i (
            .ent_fl     (w_fl[g]),
            .ent_dst    (w_dst[g]),
            .ent_s1     (w_s1[g]),
            .ent_s2     (w_s2[g]),
            .cand_dst   (new_dst_i),
            .cand_dst_v (new_dst_vld_i),
            .cand_s1    (new_src1_i),
            .cand_s1_v  (new_src1_vld_i),
            .cand_s2    (new_src2_i),
            .cand_s2_v  (new_src2_vld_i),
            .raw_o      (true_dep_o[g]),
            .waw_o      (out_dep_o[g]),
            .war_o      (anti_dep_o[g])
        );
    end

    always_comb issue_ok_o = ~|(true_dep_o | out_dep_o | anti_dep_o);
endmodule

// File: rtl/rhc_chk.sv
module rhc_chk #(
    parameter int NENT = 4,
    parameter int RW   = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            push_i,
    input logic [RW-1:0]   new_dst_i,
    input logic            new_dst_vld_i,
    input logic            new_src1_vld_i,
    input logic            new_src2_vld_i,
    input logic [NENT-1:0] true_dep_o,
    input logic [NENT-1:0] out_dep_o,
    input logic [NENT-1:0] anti_dep_o,
    input logic            issue_ok_o,
    input logic [NENT-1:0] slot_occ_o,
    input logic            win_full_o
);
    // R5
    hazard_blocks_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(true_dep_o | out_dep_o | anti_dep_o)) |-> !issue_ok_o);

    // R4
    zero_dst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!new_dst_vld_i || (new_dst_i == '0)) |-> ((out_dep_o | anti_dep_o) == '0));

    // R4
    no_src_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!new_src1_vld_i && !new_src2_vld_i) |-> (true_dep_o == '0));

    // R10
    empty_slot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((true_dep_o | out_dep_o | anti_dep_o) & ~slot_occ_o) == '0);

    // R7
    occ_compact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_occ_o + NENT'(1)) & slot_occ_o) == '0);

    // R6
    full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_full_o == (slot_occ_o == '1));

    // R6
    full_push_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_full_o && push_i) |=> ($countones(slot_occ_o) <= $past($countones(slot_occ_o))));
endmodule

bind reg_hazard_classifier rhc_chk #(.NENT(NENT), .RW(RW)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .push_i         (push_i),
    .new_dst_i      (new_dst_i),
    .new_dst_vld_i  (new_dst_vld_i),
    .new_src1_vld_i (new_src1_vld_i),
    .new_src2_vld_i (new_src2_vld_i),
    .true_dep_o     (true_dep_o),
    .out_dep_o      (out_dep_o),
    .anti_dep_o     (anti_dep_o),
    .issue_ok_o     (issue_ok_o),
    .slot_occ_o     (slot_occ_o),
    .win_full_o     (win_full_o)
);

// File: tb/reg_hazard_classifier_tb_top.sv
module reg_hazard_classifier_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int RW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push = 1'b0;
    logic [RW-1:0] n_dst = '0, n_s1 = '0, n_s2 = '0;
    logic n_dv = 1'b0, n_s1v = 1'b0, n_s2v = 1'b0;
    logic [N-1:0] mr = '0, mw = '0;
    logic [N-1:0] raw, waw, war, occ;
    logic issue_ok, full;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // Bench-side model of the window contents.
    bit m_v[N], m_dv[N], m_s1v[N], m_s2v[N], m_rd[N], m_wr[N];
    int m_dst[N], m_s1[N], m_s2[N];

    reg_hazard_classifier #(.NENT(N), .RW(RW)) dut_i (
        .clk(clk), .rst_n(rst_n), .push_i(push),
        .new_dst_i(n_dst), .new_dst_vld_i(n_dv),
        .new_src1_i(n_s1), .new_src1_vld_i(n_s1v),
        .new_src2_i(n_s2), .new_src2_vld_i(n_s2v),
        .mark_read_i(mr), .mark_written_i(mw),
        .true_dep_o(raw), .out_dep_o(waw), .anti_dep_o(war),
        .issue_ok_o(issue_ok), .slot_occ_o(occ), .win_full_o(full)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d cycles expected=finish", cyc);
            summary();
            $finish;
        end
    end

    task automatic ck(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic cand(input int d, input bit dv, input int a, input bit av, input int b, input bit bv);
        n_dst = RW'(d); n_dv = dv; n_s1 = RW'(a); n_s1v = av; n_s2 = RW'(b); n_s2v = bv;
    endtask

    function automatic int model_cnt();
        int c = 0;
        for (int i = 0; i < N; i++) if (m_v[i]) c++;
        return c;
    endfunction

    task automatic model_update(input bit p, input logic [N-1:0] r, input logic [N-1:0] w);
        int nret = 0;
        bit stop = 0;
        int c = model_cnt();
        for (int i = 0; i < N; i++) begin
            if (!stop && m_v[i] && m_wr[i]) nret++;
            else stop = 1;
        end
        for (int i = 0; i < N; i++) begin
            if (m_v[i]) begin
                if (r[i] || w[i]) m_rd[i] = 1;
                if (w[i]) m_wr[i] = 1;
            end
        end
        for (int i = 0; i < N; i++) begin
            if (i + nret < N) begin
                m_v[i] = m_v[i+nret]; m_dv[i] = m_dv[i+nret]; m_s1v[i] = m_s1v[i+nret];
                m_s2v[i] = m_s2v[i+nret]; m_rd[i] = m_rd[i+nret]; m_wr[i] = m_wr[i+nret];
                m_dst[i] = m_dst[i+nret]; m_s1[i] = m_s1[i+nret]; m_s2[i] = m_s2[i+nret];
            end else begin
                m_v[i] = 0; m_dv[i] = 0; m_s1v[i] = 0; m_s2v[i] = 0; m_rd[i] = 0; m_wr[i] = 0;
                m_dst[i] = 0; m_s1[i] = 0; m_s2[i] = 0;
            end
        end
        if (p && c < N) begin
            int k = c - nret;
            m_v[k] = 1; m_dv[k] = n_dv; m_s1v[k] = n_s1v; m_s2v[k] = n_s2v;
            m_rd[k] = 0; m_wr[k] = 0;
            m_dst[k] = int'(n_dst); m_s1[k] = int'(n_s1); m_s2[k] = int'(n_s2);
        end
    endtask

    // Called just after a falling edge; returns just after the next one.
    task automatic step(input bit p, input logic [N-1:0] r, input logic [N-1:0] w);
        push = p; mr = r; mw = w;
        @(posedge clk);
        model_update(p, r, w);
        #1;
        push = 1'b0; mr = '0; mw = '0;
        @(negedge clk);
    endtask

    function automatic logic [N-1:0] occ_exp();
        logic [N-1:0] o;
        for (int i = 0; i < N; i++) o[i] = m_v[i];
        return o;
    endfunction

    task automatic check_model(input string where);
        logic [N-1:0] er, ew, ea;
        for (int i = 0; i < N; i++) begin
            bit live = m_v[i] && m_dv[i] && (m_dst[i] != 0) && !m_wr[i];
            bit cw = n_dv && (n_dst != 0);
            er[i] = live && ((n_s1v && int'(n_s1) == m_dst[i]) || (n_s2v && int'(n_s2) == m_dst[i]));
            ew[i] = live && cw && (int'(n_dst) == m_dst[i]);
            ea[i] = m_v[i] && !m_rd[i] && cw &&
                    ((m_s1v[i] && m_s1[i] == int'(n_dst)) || (m_s2v[i] && m_s2[i] == int'(n_dst)));
        end
        ck({"R1 true-dep ", where}, raw, er);
        ck({"R2 out-dep ", where}, waw, ew);
        ck({"R3 anti-dep ", where}, war, ea);
        ck({"R5 issue-ok ", where}, {{(N-1){1'b0}}, issue_ok}, {{(N-1){1'b0}}, ~|(er | ew | ea)});
        ck({"R10 empty slots ", where}, (raw | waw | war) & ~occ, '0);
        if (!n_dv || n_dst == '0) ck({"R4 dst zero/invalid ", where}, waw | war, '0);
        if ((!n_s1v || n_s1 == '0) && (!n_s2v || n_s2 == '0)) ck({"R4 srcs zero/invalid ", where}, raw, '0);
    endtask

    // Every candidate register and valid combination against the current window.
    task automatic sweep(input string where);
        ck({"R7 occupancy ", where}, occ, occ_exp());
        for (int d = 0; d < (1 << RW); d++)
            for (int a = 0; a < (1 << RW); a++)
                for (int b = 0; b < (1 << RW); b++)
                    for (int vm = 0; vm < 8; vm++) begin
                        cand(d, vm[0], a, vm[1], b, vm[2]);
                        #1;
                        check_model(where);
                    end
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_dv[i] = 0; m_s1v[i] = 0; m_s2v[i] = 0; m_rd[i] = 0; m_wr[i] = 0;
            m_dst[i] = 0; m_s1[i] = 0; m_s2[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        cand(3, 1, 3, 1, 3, 1);
        #1;
        ck("R6 empty after reset", occ, '0);
        ck("R6 not full after reset", {{(N-1){1'b0}}, full}, '0);
        ck("R5 issue-ok after reset", {{(N-1){1'b0}}, issue_ok}, {{(N-1){1'b0}}, 1'b1});

        // R9: example sequence
        cand(3, 1, 3, 1, 5, 1); step(1, '0, '0);      // I1 -> slot 0
        step(0, 4'b0001, '0);                          // I1 operands read
        cand(4, 1, 3, 1, 0, 0); #1;                    // I2
        ck("R9 I2 true", raw, 4'b0001);
        ck("R9 I2 out", waw, 4'b0000);
        ck("R9 I2 anti", war, 4'b0000);
        step(1, '0, '0);                               // I2 -> slot 1
        cand(3, 1, 5, 1, 0, 0); #1;                    // I3
        ck("R9 I3 true", raw, 4'b0000);
        ck("R9 I3 out", waw, 4'b0001);
        ck("R9 I3 anti", war, 4'b0010);
        ck("R9 I3 blocked", {{(N-1){1'b0}}, issue_ok}, '0);
        step(1, '0, '0);                               // I3 -> slot 2
        step(0, '0, 4'b0001);                          // I1 written
        step(0, '0, '0);                               // I1 retires
        ck("R7 after single retire", occ, 4'b0011);
        cand(7, 1, 3, 1, 4, 1); #1;                    // I4
        ck("R9 I4 true", raw, 4'b0011);
        ck("R9 I4 out", waw, 4'b0000);
        ck("R9 I4 anti", war, 4'b0000);
        step(0, '0, 4'b1111);                          // marks on 2,3 are on empty slots
        step(0, '0, '0);
        ck("R7 drained", occ, 4'b0000);

        // Full window, then a dropped push
        cand(3, 1, 1, 1, 2, 1); step(1, '0, '0);
        cand(5, 1, 3, 1, 0, 1); step(1, '0, '0);
        cand(0, 1, 6, 1, 7, 0); step(1, '0, '0);
        cand(6, 0, 4, 1, 5, 1); step(1, '0, '0);
        #1;
        ck("R6 full flag", {{(N-1){1'b0}}, full}, {{(N-1){1'b0}}, 1'b1});
        cand(6, 1, 0, 0, 0, 0); #1;
        ck("R8 unread entry anti", war & 4'b0100, 4'b0100);
        cand(1, 1, 1, 1, 1, 1); step(1, '0, '0);       // dropped
        ck("R6 push while full dropped", occ, 4'b1111);
        sweep("full window");

        // Written entry behind an unwritten one stays; write implies read
        step(0, 4'b0001, 4'b0100);
        step(0, '0, '0);
        ck("R7 no retire past unwritten head", occ, 4'b1111);
        cand(6, 1, 0, 0, 0, 0); #1;
        ck("R8 written implies read", war & 4'b0100, 4'b0000);
        sweep("after marks");

        // Head written: only the head leaves
        step(0, '0, 4'b0001);
        step(0, '0, '0);
        ck("R7 partial retire", occ, 4'b0111);
        sweep("after partial retire");

        // Push and a new write at the same edge, then a two-entry retirement
        cand(2, 1, 6, 1, 3, 1); step(1, '0, 4'b0001);
        ck("R6 push lands in slot 3", occ, 4'b1111);
        step(0, '0, '0);
        ck("R7 two retire at once", occ, 4'b0011);
        sweep("after double retire");

        // Marks on empty slots, and a mark on the slot being filled
        step(0, '0, 4'b1100);
        cand(4, 1, 2, 1, 6, 1); step(1, 4'b0100, 4'b0100);
        cand(4, 1, 0, 0, 0, 0); #1;
        ck("R8 mark on filling slot ignored", waw & 4'b0100, 4'b0100);
        cand(7, 1, 4, 1, 0, 0); step(1, '0, 4'b1000);
        sweep("after empty-slot marks");

        summary();
        $finish;
    end
endmodule